// File: doc/BRIEF.md
# Scan Line Start Address Generator

This block works out, for a raster display controller, the display-memory address at which fetching begins on each scan line. Software sets up a frame origin, a row pitch, an addressing-unit select, the number of scan lines in a character row, an initial row-scan value, a coarse pan of zero to three address units, a split line number and a flag that keeps the lower window from panning. The block latches all of these at the frame strobe. It then steps the row-scan count on every line strobe. Each time the count rolls over, it moves the line address forward by one row pitch.

At the split line the line address drops to zero and the row-scan count restarts at zero. This forms a fixed lower window that ignores the upper window's origin and initial row scan. A set flag also removes the coarse pan from that window. The address space is 16 bits wide and wraps from its top back to zero. Pixel fetch, colour handling and sync timing are done elsewhere.

Top module: `disp_line_addr_gen`

## Requirements
- R1: After reset, line_addr, row_scan and split_active are all zero.
- R2: One cycle after a frame_stb pulse, line_addr equals cfg_base_addr plus cfg_addr_pan (modulo 2^16), row_scan equals cfg_scan_init and split_active is 0. This holds whenever cfg_split_line is nonzero.
- R3: Changes on any cfg_* input do not affect the outputs, the row pitch or the panning until the next frame_stb.
- R4: Each line_stb without frame_stb adds one to row_scan. When row_scan equals the latched scan maximum, it goes to 0 instead. The row base address moves only on that roll-over.
- R5: The row pitch is cfg_row_pitch times 8 when cfg_quad_sel is 1. Otherwise it is times 4 when cfg_unit_sel is 0 and times 2 when cfg_unit_sel is 1.
- R6: Address arithmetic wraps modulo 2^16.
- R7: Scan lines are numbered from 0 at the frame strobe. On the line_stb that begins line number cfg_split_line, the row base becomes 0, row_scan becomes 0 and split_active becomes 1. All three stay that way, apart from normal row stepping, until the next frame_stb. A cfg_split_line of 0 splits at the frame strobe itself.
- R8: In the lower window, line_addr omits the coarse pan when cfg_split_nopan was latched as 1. It keeps the coarse pan when that flag was latched as 0.
- R9: If cfg_scan_init is greater than the scan maximum, the first line_stb rolls row_scan over to 0 and advances the row base.
- R10: Every frame_stb clears split_active, except that a cfg_split_line of 0 sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb | input | 1 | One-cycle pulse at the start of each scan line |
| frame_stb | input | 1 | One-cycle pulse at the end of vertical retrace |
| cfg_base_addr | input | 16 | Upper-window frame origin |
| cfg_row_pitch | input | 8 | Row pitch before scaling |
| cfg_quad_sel | input | 1 | Selects a four-byte addressing unit |
| cfg_unit_sel | input | 1 | Selects byte (1) or word (0) unit when quad is off |
| cfg_scan_max | input | 5 | Last row-scan value of a character row |
| cfg_scan_init | input | 5 | Row-scan value at frame start |
| cfg_addr_pan | input | 2 | Coarse pan added to the line address |
| cfg_split_line | input | 10 | Scan line number where the lower window starts |
| cfg_split_nopan | input | 1 | Removes coarse pan in the lower window |
| line_addr | output | 16 | Start address of the current scan line |
| row_scan | output | 5 | Current row-scan count |
| split_active | output | 1 | Lower window in progress |

## Verification
The assertions check four things on every cycle. The row-scan count never passes the latched maximum after a line strobe. The row base loads the origin at the frame strobe, goes to zero at the split and stays put with no event. The split flag falls only at a frame strobe, and a locked lower window shows no pan. Only the bench scenarios can show the actual addresses produced by each pitch scaling. They also show the timing of the split against the line count, the wrap at the top of the address space, the handling of an oversize initial row scan, and the fact that configuration writes wait for the next frame.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [1:0] {
      UNIT_BYTE  = 2'd0,
      UNIT_WORD  = 2'd1,
      UNIT_QUAD  = 2'd2
   } unit_e;

   function automatic unit_e decode_unit(input logic quad, input logic bytesel);
      if (quad)         return UNIT_QUAD;
      else if (bytesel) return UNIT_BYTE;
      else              return UNIT_WORD;
   endfunction

endpackage

// File: rtl/lsa_cfg_shadow.sv
module lsa_cfg_shadow
   import lsa_pkg::*;
#(
   parameter int OFFS_W = 8,
   parameter int SCAN_W = 5,
   parameter int LC_W   = 10,
   parameter int PAN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [OFFS_W-1:0] in_pitch,
   input  logic              in_quad,
   input  logic              in_unit,
   input  logic [SCAN_W-1:0] in_max,
   input  logic [PAN_W-1:0]  in_pan,
   input  logic [LC_W-1:0]   in_split,
   input  logic              in_nopan,
   output logic [OFFS_W-1:0] sh_pitch,
   output unit_e             sh_unit,
   output logic [SCAN_W-1:0] sh_max,
   output logic [PAN_W-1:0]  sh_pan,
   output logic [LC_W-1:0]   sh_split,
   output logic              sh_nopan
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_pitch <= '0;
         sh_unit  <= UNIT_WORD;
         sh_max   <= '0;
         sh_pan   <= '0;
         sh_split <= '1;
         sh_nopan <= 1'b0;
      end else if (load) begin
         sh_pitch <= in_pitch;
         sh_unit  <= decode_unit(in_quad, in_unit);
         sh_max   <= in_max;
         sh_pan   <= in_pan;
         sh_split <= in_split;
         sh_nopan <= in_nopan;
      end
   end

   // R3: shadow copies move only on the frame strobe
   a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(sh_pitch) && $stable(sh_max) && $stable(sh_pan)
                 && $stable(sh_split) && $stable(sh_nopan)));

endmodule

// File: rtl/lsa_scan_ctrl.sv
module lsa_scan_ctrl #(
   parameter int SCAN_W = 5,
   parameter int LC_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_stb,
   input  logic              frame_stb,
   input  logic [SCAN_W-1:0] init_scan,
   input  logic [LC_W-1:0]   init_split,
   input  logic [SCAN_W-1:0] sh_max,
   input  logic [LC_W-1:0]   sh_split,
   output logic [SCAN_W-1:0] row_scan,
   output logic              split_on,
   output logic              frame_zero,
   output logic              split_hit,
   output logic              row_adv
);

   logic [LC_W-1:0] line_cnt;
   logic [LC_W-1:0] next_line;
   logic            step;

   always_comb begin
      next_line  = line_cnt + 1'b1;
      step       = line_stb && !frame_stb;
      frame_zero = frame_stb && (init_split == '0);
      split_hit  = step && !split_on && (next_line == sh_split);
      row_adv    = step && !split_hit && (row_scan >= sh_max);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         row_scan <= '0;
         split_on <= 1'b0;
      end else if (frame_stb) begin
         line_cnt <= '0;
         row_scan <= frame_zero ? '0 : init_scan;
         split_on <= frame_zero;
      end else if (step) begin
         line_cnt <= next_line;
         if (split_hit) begin
            row_scan <= '0;
            split_on <= 1'b1;
         end else if (row_adv) begin
            row_scan <= '0;
         end else begin
            row_scan <= row_scan + 1'b1;
         end
      end
   end

   // R4: after a line step the count never exceeds the latched maximum
   a_r4_scan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (row_scan <= sh_max));

   // R10: a frame strobe leaves the split flag set only for a zero split line
   a_r10_split_clear: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> (split_on == ($past(init_split) == '0)));

   // R7: the split flag only drops at a frame strobe
   a_r7_split_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(split_on) |-> $past(frame_stb));

endmodule

// File: rtl/lsa_addr_accum.sv
module lsa_addr_accum
   import lsa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFFS_W = 8,
   parameter int PAN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              frame_zero,
   input  logic              split_hit,
   input  logic              row_adv,
   input  logic              split_on,
   input  logic [ADDR_W-1:0] init_base,
   input  logic [OFFS_W-1:0] sh_pitch,
   input  unit_e             sh_unit,
   input  logic [PAN_W-1:0]  sh_pan,
   input  logic              sh_nopan,
   output logic [ADDR_W-1:0] row_base,
   output logic [ADDR_W-1:0] line_addr
);

   localparam int NUM_UNITS = 3;

   logic [ADDR_W-1:0] pitch_opt [NUM_UNITS];
   logic [ADDR_W-1:0] stride;
   logic [PAN_W-1:0]  pan_eff;

   // one scaled pitch per addressing unit: shift by 1, 2, 3
   for (genvar g = 0; g < NUM_UNITS; g++) begin : g_pitch
      assign pitch_opt[g] = ADDR_W'(sh_pitch) << (g + 1);
   end

   always_comb begin
      unique case (sh_unit)
         UNIT_BYTE: stride = pitch_opt[0];
         UNIT_WORD: stride = pitch_opt[1];
         UNIT_QUAD: stride = pitch_opt[2];
         default:   stride = pitch_opt[1];
      endcase
      pan_eff   = (split_on && sh_nopan) ? '0 : sh_pan;
      line_addr = row_base + ADDR_W'(pan_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            row_base <= '0;
      else if (frame_stb)    row_base <= frame_zero ? '0 : init_base;
      else if (split_hit)    row_base <= '0;
      else if (row_adv)      row_base <= row_base + stride;
   end

   // R2: the frame strobe loads the origin
   a_r2_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !frame_zero) |=> (row_base == $past(init_base)));

   // R7: the split drops the base to zero
   a_r7_split_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb && split_hit) |=> (row_base == '0));

   // R4: the base only moves on a roll-over, split or frame event
   a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb && !split_hit && !row_adv) |=> $stable(row_base));

   // R8: a locked lower window carries no pan
   a_r8_lower_nopan: assert property (@(posedge clk) disable iff (!rst_n)
      (split_on && sh_nopan) |-> (line_addr == row_base));

endmodule

// File: rtl/disp_line_addr_gen.sv
module disp_line_addr_gen
   import lsa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFFS_W = 8,
   parameter int SCAN_W = 5,
   parameter int LC_W   = 10,
   parameter int PAN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_stb,
   input  logic              frame_stb,
   input  logic [ADDR_W-1:0] cfg_base_addr,
   input  logic [OFFS_W-1:0] cfg_row_pitch,
   input  logic              cfg_quad_sel,
   input  logic              cfg_unit_sel,
   input  logic [SCAN_W-1:0] cfg_scan_max,
   input  logic [SCAN_W-1:0] cfg_scan_init,
   input  logic [PAN_W-1:0]  cfg_addr_pan,
   input  logic [LC_W-1:0]   cfg_split_line,
   input  logic              cfg_split_nopan,
   output logic [ADDR_W-1:0] line_addr,
   output logic [SCAN_W-1:0] row_scan,
   output logic              split_active
);

   if (ADDR_W < OFFS_W + 3) begin : g_chk_addr
      $error("ADDR_W too narrow for the largest scaled pitch");
   end
   if (PAN_W >= ADDR_W) begin : g_chk_pan
      $error("PAN_W must be narrower than ADDR_W");
   end
   if (SCAN_W < 1 || LC_W < 1) begin : g_chk_cnt
      $error("counter widths must be positive");
   end

   logic [OFFS_W-1:0] sh_pitch;
   unit_e             sh_unit;
   logic [SCAN_W-1:0] sh_max;
   logic [PAN_W-1:0]  sh_pan;
   logic [LC_W-1:0]   sh_split;
   logic              sh_nopan;
   logic              frame_zero;
   logic              split_hit;
   logic              row_adv;
   logic [ADDR_W-1:0] row_base;

   lsa_cfg_shadow #(
      .OFFS_W(OFFS_W), .SCAN_W(SCAN_W), .LC_W(LC_W), .PAN_W(PAN_W)
   ) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (frame_stb),
      .in_pitch (cfg_row_pitch),
      .in_quad  (cfg_quad_sel),
      .in_unit  (cfg_unit_sel),
      .in_max   (cfg_scan_max),
      .in_pan   (cfg_addr_pan),
      .in_split (cfg_split_line),
      .in_nopan (cfg_split_nopan),
      .sh_pitch (sh_pitch),
      .sh_unit  (sh_unit),
      .sh_max   (sh_max),
      .sh_pan   (sh_pan),
      .sh_split (sh_split),
      .sh_nopan (sh_nopan)
   );

   lsa_scan_ctrl #(
      .SCAN_W(SCAN_W), .LC_W(LC_W)
   ) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_stb   (line_stb),
      .frame_stb  (frame_stb),
      .init_scan  (cfg_scan_init),
      .init_split (cfg_split_line),
      .sh_max     (sh_max),
      .sh_split   (sh_split),
      .row_scan   (row_scan),
      .split_on   (split_active),
      .frame_zero (frame_zero),
      .split_hit  (split_hit),
      .row_adv    (row_adv)
   );

   lsa_addr_accum #(
      .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .PAN_W(PAN_W)
   ) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_stb  (frame_stb),
      .frame_zero (frame_zero),
      .split_hit  (split_hit),
      .row_adv    (row_adv),
      .split_on   (split_active),
      .init_base  (cfg_base_addr),
      .sh_pitch   (sh_pitch),
      .sh_unit    (sh_unit),
      .sh_pan     (sh_pan),
      .sh_nopan   (sh_nopan),
      .row_base   (row_base),
      .line_addr  (line_addr)
   );

   // R9: an oversize initial scan rolls over on the first line strobe
   a_r9_oversize_init: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stb && !frame_stb && !split_active && (row_scan > sh_max)) |=> (row_scan == '0));

endmodule

// File: tb/disp_line_addr_gen_tb_top.sv
module disp_line_addr_gen_tb_top;

   typedef struct packed {
      logic [15:0] base;
      logic [7:0]  pitch;
      logic        quad;
      logic        unitb;
      logic [4:0]  smax;
      logic [4:0]  sinit;
      logic [1:0]  pan;
      logic [9:0]  split;
      logic        nopan;
      logic [7:0]  nlines;
      logic [15:0] e_addr;
      logic [4:0]  e_scan;
      logic        e_split;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      // R5 byte unit (x2), max 0: every line rolls
      '{16'h1000, 8'h20, 1'b0, 1'b1, 5'd0,  5'd0, 2'd0, 10'd1023, 1'b0, 8'd3,  16'h10C0, 5'd0, 1'b0},
      // R5 word unit (x4), R4 roll at 16 lines
      '{16'h0200, 8'h28, 1'b0, 1'b0, 5'd15, 5'd0, 2'd1, 10'd1023, 1'b0, 8'd20, 16'h02A1, 5'd4, 1'b0},
      // R5 quad unit (x8), initial scan 3
      '{16'h0000, 8'h10, 1'b1, 1'b0, 5'd7,  5'd3, 2'd2, 10'd1023, 1'b0, 8'd10, 16'h0082, 5'd5, 1'b0},
      // R6 wrap past top of address space
      '{16'hFFF0, 8'h04, 1'b0, 1'b1, 5'd0,  5'd0, 2'd3, 10'd1023, 1'b0, 8'd3,  16'h000B, 5'd0, 1'b0},
      // R7 R8 split with pan removed
      '{16'h4000, 8'h28, 1'b0, 1'b0, 5'd1,  5'd0, 2'd2, 10'd5,    1'b1, 8'd7,  16'h00A0, 5'd0, 1'b1},
      // R7 R8 split with pan kept
      '{16'h4000, 8'h28, 1'b0, 1'b0, 5'd1,  5'd0, 2'd2, 10'd5,    1'b0, 8'd7,  16'h00A2, 5'd0, 1'b1},
      // R7 one line before the split
      '{16'h4000, 8'h28, 1'b0, 1'b0, 5'd1,  5'd0, 2'd2, 10'd5,    1'b1, 8'd4,  16'h4142, 5'd0, 1'b0},
      // R9 oversize initial scan
      '{16'h0100, 8'h01, 1'b0, 1'b1, 5'd3,  5'd9, 2'd0, 10'd1023, 1'b0, 8'd1,  16'h0102, 5'd0, 1'b0},
      // R7 split line 0 splits at frame strobe
      '{16'h5000, 8'h10, 1'b0, 1'b0, 5'd3,  5'd2, 2'd1, 10'd0,    1'b0, 8'd0,  16'h0001, 5'd0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_stb = 1'b0;
   logic        frame_stb = 1'b0;
   logic [15:0] cfg_base_addr = '0;
   logic [7:0]  cfg_row_pitch = '0;
   logic        cfg_quad_sel = 1'b0;
   logic        cfg_unit_sel = 1'b0;
   logic [4:0]  cfg_scan_max = '0;
   logic [4:0]  cfg_scan_init = '0;
   logic [1:0]  cfg_addr_pan = '0;
   logic [9:0]  cfg_split_line = '1;
   logic        cfg_split_nopan = 1'b0;
   logic [15:0] line_addr;
   logic [4:0]  row_scan;
   logic        split_active;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   disp_line_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
      .cfg_base_addr(cfg_base_addr), .cfg_row_pitch(cfg_row_pitch),
      .cfg_quad_sel(cfg_quad_sel), .cfg_unit_sel(cfg_unit_sel),
      .cfg_scan_max(cfg_scan_max), .cfg_scan_init(cfg_scan_init),
      .cfg_addr_pan(cfg_addr_pan), .cfg_split_line(cfg_split_line),
      .cfg_split_nopan(cfg_split_nopan),
      .line_addr(line_addr), .row_scan(row_scan), .split_active(split_active)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      cfg_base_addr   = v.base;
      cfg_row_pitch   = v.pitch;
      cfg_quad_sel    = v.quad;
      cfg_unit_sel    = v.unitb;
      cfg_scan_max    = v.smax;
      cfg_scan_init   = v.sinit;
      cfg_addr_pan    = v.pan;
      cfg_split_line  = v.split;
      cfg_split_nopan = v.nopan;
   endtask

   task automatic pulse_frame();
      @(negedge clk) frame_stb = 1'b1;
      @(negedge clk) frame_stb = 1'b0;
   endtask

   task automatic pulse_line();
      @(negedge clk) line_stb = 1'b1;
      @(negedge clk) line_stb = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "line_addr", int'(line_addr), 0);
      check("R1", "row_scan", int'(row_scan), 0);
      check("R1", "split_active", int'(split_active), 0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         apply(VECS[i]);
         pulse_frame();
         for (int k = 0; k < int'(VECS[i].nlines); k++) pulse_line();
         check("R4/R5/R6/R7/R8/R9 vec", "line_addr", int'(line_addr), int'(VECS[i].e_addr));
         check("R4 vec", "row_scan", int'(row_scan), int'(VECS[i].e_scan));
         check("R7 vec", "split_active", int'(split_active), int'(VECS[i].e_split));
      end

      // R2 origin plus pan right after the frame strobe
      v = VECS[1];
      apply(v);
      pulse_frame();
      check("R2", "line_addr", int'(line_addr), 16'h0201);
      check("R2", "row_scan", int'(row_scan), 0);

      // R3 writes wait for the next frame strobe
      v = VECS[0];
      apply(v);
      pulse_frame();
      repeat (3) pulse_line();
      @(negedge clk);
      cfg_base_addr = 16'hAAAA;
      cfg_row_pitch = 8'hFF;
      cfg_quad_sel  = 1'b1;
      cfg_addr_pan  = 2'd3;
      cfg_scan_max  = 5'd9;
      repeat (2) @(negedge clk);
      check("R3", "line_addr held", int'(line_addr), 16'h10C0);
      pulse_line();
      check("R3", "old pitch used", int'(line_addr), 16'h1100);
      check("R3", "old max used", int'(row_scan), 0);

      // R10 split flag cleared by next frame strobe
      v = VECS[4];
      apply(v);
      pulse_frame();
      repeat (5) pulse_line();
      check("R7", "split after 5 lines", int'(split_active), 1);
      v.split = 10'd1023;
      v.pan   = 2'd1;
      apply(v);
      pulse_frame();
      check("R10", "split cleared", int'(split_active), 0);
      check("R10", "line_addr after frame", int'(line_addr), 16'h4001);

      finish_run();
   end

endmodule